// File: doc/BRIEF.md
# Sub-Dword Operand Select and Destination Merge

This block conditions the operands and the result of a 32-bit integer add. Each of the two sources passes through a field selector that picks one byte, one 16-bit half or the whole 32-bit value. The picked field is moved down to bit 0 and zero-extended before the two values are added. The sum is then written into a byte, half or whole-word field of the destination. A three-way policy decides what happens to the destination bits outside that field: they are cleared, they take a sign fill, or they keep the previous destination contents.

Every select input has its own 3-bit code, so the two sources and the destination are chosen independently. The merged value is held in an output register, so a result appears one clock after its inputs are presented. The path has no state beyond that register, so the design has no state machine. Its only sequencing is reset, followed by one capture on every clock.

Top module: `sdm_operand_merge`

## Requirements
- R1: While rst_n is low, dst_o reads 0, whatever the data inputs carry.
- R2: Select code k picks a field of its source. Codes 0 to 3 pick byte k, at bits [8k+7:8k]. Codes 4 and 5 pick half k-4, at bits [16(k-4)+15:16(k-4)]. Code 6 picks bits [31:0]. The field is shifted down to bit 0, and every bit above it is zero before the add.
- R3: Select code 7 on any of the three select inputs behaves exactly like code 6, the whole word.
- R4: The sum of the two conditioned sources is taken modulo 2^32. Its low bits, as many as the destination field is wide, appear in dst_o starting at that field's lowest bit position.
- R5: With policy code 0 (clear), every dst_o bit outside the destination field is 0.
- R6: With policy code 1 (sign fill), the dst_o bits above the field all equal the field's most significant bit, and the dst_o bits below the field are 0.
- R7: With policy code 2 (keep), every dst_o bit outside the field equals the matching bit of dst_old_i.
- R8: Policy code 3 behaves exactly like policy code 2.
- R9: When the destination code selects the whole word, dst_o equals the full 32-bit sum under every policy code.
- R10: dst_o changes only at a rising clock edge, and it shows the result of the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_i | input | 32 | First source value |
| src1_i | input | 32 | Second source value |
| dst_old_i | input | 32 | Previous destination contents, used by the keep policy |
| src0_sel_i | input | 3 | Field code for the first source |
| src1_sel_i | input | 3 | Field code for the second source |
| dst_sel_i | input | 3 | Field code for the destination |
| unused_pol_i | input | 2 | Policy for destination bits outside the field |
| dst_o | output | 32 | Registered merged destination |

## Verification
The bench sweeps every combination of the three field codes and the policy code, and it uses data whose sums carry past the field width and whose field tops are set. A design that forgot to truncate would leak carry bits into the neighbouring field. A design that took the sign from the wrong bit would fill with the wrong value, and a design that sign-filled below the field would corrupt low bits that should be zero. Further cases check that the reserved codes 7 and 3 act as their defined aliases, and that the whole-word destination ignores the policy. Another check changes the inputs just after a clock edge, which would catch a result that leaks through combinationally instead of waiting for the next edge.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int DW = 32;
    localparam int BW = DW / 4;
    localparam int HW = DW / 2;
    localparam int GW = $clog2(DW) + 1;

    typedef enum logic [2:0] {
        FS_BYTE0 = 3'd0,
        FS_BYTE1 = 3'd1,
        FS_BYTE2 = 3'd2,
        FS_BYTE3 = 3'd3,
        FS_HALF0 = 3'd4,
        FS_HALF1 = 3'd5,
        FS_WHOLE = 3'd6,
        FS_RSVD  = 3'd7
    } fld_sel_e;

    typedef enum logic [1:0] {
        UP_CLEAR = 2'd0,
        UP_SIGN  = 2'd1,
        UP_KEEP  = 2'd2,
        UP_RSVD  = 2'd3
    } unused_pol_e;

    typedef struct packed {
        logic [GW-1:0] off;
        logic [GW-1:0] width;
    } fld_geom_t;

    function automatic fld_geom_t sel_geom(input logic [2:0] code);
        fld_geom_t g;
        case (code)
            FS_BYTE0: g = '{off: GW'(0),      width: GW'(BW)};
            FS_BYTE1: g = '{off: GW'(BW),     width: GW'(BW)};
            FS_BYTE2: g = '{off: GW'(2 * BW), width: GW'(BW)};
            FS_BYTE3: g = '{off: GW'(3 * BW), width: GW'(BW)};
            FS_HALF0: g = '{off: GW'(0),      width: GW'(HW)};
            FS_HALF1: g = '{off: GW'(HW),     width: GW'(HW)};
            default:  g = '{off: GW'(0),      width: GW'(DW)};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sdm_field_extract.sv
module sdm_field_extract
    import sdm_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic [2:0]        sel_i,
    input  logic [DATA_W-1:0] src_i,
    output logic [DATA_W-1:0] fld_o
);

    fld_geom_t          geom;
    logic [DATA_W-1:0]  shifted;
    logic [DATA_W-1:0]  wmask;

    always_comb begin
        geom    = sel_geom(sel_i);
        shifted = src_i >> geom.off;
        for (int i = 0; i < DATA_W; i++) begin
            wmask[i] = (i < int'(geom.width));
        end
        fld_o = shifted & wmask;
    end

    // R2: a byte pick must leave every bit above bit 7 at zero
    always_comb begin
        if (!$isunknown(sel_i) && (sel_i <= 3'(FS_BYTE3))) begin
            p_zero_ext_r2: assert (fld_o[DATA_W-1:BW] == '0)
                else $error("byte field not zero-extended");
        end
    end

endmodule

// File: rtl/sdm_dst_merge.sv
module sdm_dst_merge
    import sdm_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic [DATA_W-1:0] sum_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [2:0]        sel_i,
    input  logic [1:0]        pol_i,
    output logic [DATA_W-1:0] merged_o
);

    fld_geom_t          geom;
    logic [DATA_W-1:0]  fmask;
    logic [DATA_W-1:0]  above_m;
    logic [DATA_W-1:0]  placed;
    logic [DATA_W-1:0]  top_sh;
    logic [DATA_W-1:0]  fill;
    logic               top_bit;

    always_comb begin
        geom = sel_geom(sel_i);
        for (int i = 0; i < DATA_W; i++) begin
            fmask[i]   = (i >= int'(geom.off)) &&
                         (i < int'(geom.off) + int'(geom.width));
            above_m[i] = (i >= int'(geom.off) + int'(geom.width));
        end
        placed  = (sum_i << geom.off) & fmask;
        top_sh  = sum_i >> (geom.width - GW'(1));
        top_bit = top_sh[0];
    end

    always_comb begin
        unique case (pol_i)
            UP_CLEAR: fill = '0;
            UP_SIGN:  fill = above_m & {DATA_W{top_bit}};
            UP_KEEP:  fill = old_i & ~fmask;
            UP_RSVD:  fill = old_i & ~fmask;
            default:  fill = '0;
        endcase
        merged_o = placed | (fill & ~fmask);
    end

endmodule

// File: rtl/sdm_operand_merge.sv
module sdm_operand_merge
    import sdm_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src0_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [DATA_W-1:0] dst_old_i,
    input  logic [2:0]        src0_sel_i,
    input  logic [2:0]        src1_sel_i,
    input  logic [2:0]        dst_sel_i,
    input  logic [1:0]        unused_pol_i,
    output logic [DATA_W-1:0] dst_o
);

    localparam int NSRC = 2;

    logic [DATA_W-1:0] src_arr [NSRC];
    logic [2:0]        sel_arr [NSRC];
    logic [DATA_W-1:0] fld_arr [NSRC];
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] res_q;

    assign src_arr[0] = src0_i;
    assign src_arr[1] = src1_i;
    assign sel_arr[0] = src0_sel_i;
    assign sel_arr[1] = src1_sel_i;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sdm_field_extract #(.DATA_W(DATA_W)) u_ext (
            .sel_i (sel_arr[s]),
            .src_i (src_arr[s]),
            .fld_o (fld_arr[s])
        );
    end

    assign sum = fld_arr[0] + fld_arr[1];

    sdm_dst_merge #(.DATA_W(DATA_W)) u_merge (
        .sum_i    (sum),
        .old_i    (dst_old_i),
        .sel_i    (dst_sel_i),
        .pol_i    (unused_pol_i),
        .merged_o (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= merged;
    end

    assign dst_o = res_q;

    // R5: clear policy with a byte-0 destination zeroes bits above it
    p_clear_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unused_pol_i == UP_CLEAR && dst_sel_i == FS_BYTE0)
        |=> (dst_o[DATA_W-1:BW] == '0));

    // R6: sign policy with a low-half destination replicates bit 15 upward
    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unused_pol_i == UP_SIGN && dst_sel_i == FS_HALF0)
        |=> (dst_o[DATA_W-1:HW] == {HW{dst_o[HW-1]}}));

    // R7: keep policy with a byte-1 destination leaves other bits as before
    p_keep_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unused_pol_i == UP_KEEP && dst_sel_i == FS_BYTE1)
        |=> (dst_o[DATA_W-1:2*BW] == $past(dst_old_i[DATA_W-1:2*BW]) &&
             dst_o[BW-1:0] == $past(dst_old_i[BW-1:0])));

    // R8: reserved policy code also keeps the old bits
    p_rsvd_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unused_pol_i == UP_RSVD && dst_sel_i == FS_BYTE2)
        |=> (dst_o[2*BW-1:0] == $past(dst_old_i[2*BW-1:0])));

    // R9: all-whole selects give the plain sum whatever the policy
    p_whole_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src0_sel_i == FS_WHOLE && src1_sel_i == FS_WHOLE && dst_sel_i == FS_WHOLE)
        |=> (dst_o == $past(src0_i + src1_i)));

endmodule

// File: tb/sdm_operand_merge_tb.sv
module sdm_operand_merge_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s0 = '0, s1 = '0, old = '0;
    logic [2:0]  c0 = '0, c1 = '0, cd = '0;
    logic [1:0]  pol = '0;
    logic [31:0] dout;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    sdm_operand_merge u_dut (
        .clk(clk), .rst_n(rst_n),
        .src0_i(s0), .src1_i(s1), .dst_old_i(old),
        .src0_sel_i(c0), .src1_sel_i(c1), .dst_sel_i(cd),
        .unused_pol_i(pol), .dst_o(dout)
    );

    function automatic void geom(input int code, output int o, output int w);
        if (code < 4)      begin o = 8 * code;        w = 8;  end
        else if (code < 6) begin o = 16 * (code - 4); w = 16; end
        else               begin o = 0;               w = 32; end
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, b, prev,
                                          input int ka, kb, kd, p);
        int oa, wa, ob, wb, od, wd;
        longint va, vb, total;
        logic [31:0] r;
        geom(ka, oa, wa); geom(kb, ob, wb); geom(kd, od, wd);
        va = (longint'(a) >> oa) % (64'd1 << wa);
        vb = (longint'(b) >> ob) % (64'd1 << wb);
        total = (va + vb) % (64'd1 << 32);
        for (int i = 0; i < 32; i++) begin
            if (i >= od && i < od + wd)  r[i] = total[i - od];
            else if (p == 0)             r[i] = 1'b0;
            else if (p == 1)             r[i] = (i >= od + wd) ? total[wd - 1] : 1'b0;
            else                         r[i] = prev[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, dout, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, b, prev, input int ka, kb, kd, p,
                         input string tag);
        logic [31:0] exp;
        s0 = a; s1 = b; old = prev;
        c0 = 3'(ka); c1 = 3'(kb); cd = 3'(kd); pol = 2'(p);
        exp = model(a, b, prev, ka, kb, kd, p);
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tg;
        logic [31:0] hold;
        // R1: inputs busy while reset is held
        s0 = 32'hDEADBEEF; s1 = 32'h11111111; old = 32'hFFFFFFFF;
        c0 = 3'd6; c1 = 3'd6; cd = 3'd6; pol = 2'd2;
        repeat (3) @(negedge clk);
        check("R1", 32'h0);
        rst_n = 1'b1;

        // R2: byte 2 of 0xA1B2C3D4 gives 0xB2
        apply(32'hA1B2C3D4, 32'h0, 32'h0, 2, 6, 6, 0, "R2");
        check("R2", 32'h000000B2);
        // R2: upper half, zero-extended
        apply(32'hF00D1234, 32'h1, 32'h0, 5, 6, 6, 2, "R2");
        check("R2", 32'h0000F00E);
        // R3: code 7 acts as whole word
        apply(32'h12345678, 32'hFFFF0001, 32'hAAAAAAAA, 7, 4, 7, 0, "R3");
        check("R3", 32'h12345679);
        // R4: carry out of a byte field is dropped
        apply(32'h000000FF, 32'h00000002, 32'h0, 0, 0, 1, 0, "R4");
        check("R4", 32'h00000100);
        // R6: sign fill from half 0
        apply(32'h00008000, 32'h00000001, 32'h0, 4, 6, 4, 1, "R6");
        check("R6", 32'hFFFF8001);
        // R6: below the field is zero
        apply(32'h00000080, 32'h0, 32'hFFFFFFFF, 0, 0, 1, 1, "R6");
        check("R6", 32'hFFFF8000);
        // R7 / R8: keep around byte 3
        apply(32'h5, 32'h6, 32'h89ABCDEF, 0, 0, 3, 2, "R7");
        check("R7", 32'h0BABCDEF);
        apply(32'h5, 32'h6, 32'h89ABCDEF, 0, 0, 3, 3, "R8");
        check("R8", 32'h0BABCDEF);

        // R10: changing inputs after an edge must not move the output
        apply(32'h00000010, 32'h00000020, 32'h0, 6, 6, 6, 0, "R10");
        hold = dout;
        s0 = 32'h77777777; c0 = 3'd3;
        #1;
        check("R10", hold);

        // exhaustive sweep of codes and policies
        for (int ka = 0; ka < 8; ka++)
            for (int kb = 0; kb < 8; kb++)
                for (int kd = 0; kd < 8; kd++)
                    for (int p = 0; p < 4; p++)
                        for (int rep = 0; rep < 2; rep++) begin
                            if (kd >= 6)     tg = "R9";
                            else if (p == 0) tg = "R5";
                            else if (p == 1) tg = "R6";
                            else if (p == 2) tg = "R7";
                            else             tg = "R8";
                            apply($urandom | 32'h80808080, $urandom, $urandom,
                                  ka, kb, kd, p, tg);
                        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule